// File: doc/BRIEF.md
# Universal Bus Transceiver Register

This block connects two 18-bit ports, A and B, through one storage register per direction. For each direction, one level input chooses between two kinds of operation. In pass-through operation, the output copies the opposite port's input within the same cycle. In stored operation, the output shows a register value. That register loads only on a qualifying edge of the direction's own data clock, and only while a clock-enable input, active low, permits it. When the level input returns low, the register keeps the last value that passed through.

The block runs entirely on one system clock. Each direction clock is sampled on that clock, and an edge is detected by comparing the current level with the level one cycle earlier. No latch is inferred.

Tri-state drive is modelled as a data vector plus a drive flag for each port. When a port's output enable (active low) is high, its drive flag is low and its register is untouched.

Top module: `ubt_xcvr`

## Requirements
- R1: While `rst` is high on a clock edge, both stored registers become zero. With pass-through off, `b_out` and `a_out` then read 0.
- R2: While `le_ab` is 1, `b_out` equals `a_in` in the same cycle, with no clock latency.
- R3: While `le_ab` is 0 and `clk_ab` does not change, `b_out` holds its value even when `a_in` changes.
- R4: With `le_ab` 0 and `ce_ab_n` 0, the cycle in which `clk_ab` is first seen low after being high loads `a_in` of that cycle. `b_out` shows that value from the following cycle on.
- R5: A falling `clk_ab` seen while `ce_ab_n` is 1 leaves the stored value, and so `b_out`, unchanged.
- R6: With the default edge polarity, a low-to-high change of `clk_ab` does not load the register, even when `ce_ab_n` is 0.
- R7: When `le_ab` drops from 1 to 0 with no clock edge, `b_out` keeps the `a_in` value that was present in the last cycle `le_ab` was 1.
- R8: `b_drv` is 0 exactly while `oe_ab_n` is 1, and `a_drv` is 0 exactly while `oe_ba_n` is 1. Disabling a port changes neither its stored value nor its `*_out` value.
- R9: The B-to-A direction behaves as R2 to R7 do, using `b_in`, `a_out`, `le_ba`, `clk_ba` and `ce_ba_n`. Activity in one direction never changes the other direction's stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data received on port A |
| a_out | output | 18 | Data presented to port A (B-to-A path) |
| a_drv | output | 1 | Port A drive flag |
| b_in | input | 18 | Data received on port B |
| b_out | output | 18 | Data presented to port B (A-to-B path) |
| b_drv | output | 1 | Port B drive flag |
| oe_ab_n | input | 1 | Port B output enable, active low |
| le_ab | input | 1 | A-to-B pass-through select |
| clk_ab | input | 1 | A-to-B data clock |
| ce_ab_n | input | 1 | A-to-B clock enable, active low |
| oe_ba_n | input | 1 | Port A output enable, active low |
| le_ba | input | 1 | B-to-A pass-through select |
| clk_ba | input | 1 | B-to-A data clock |
| ce_ba_n | input | 1 | B-to-A clock enable, active low |

## Verification
The bench builds the block with its defaults: an 18-bit width and the falling-edge variant of the edge detector. The full width lets patterns with the top and bottom bits set in opposite senses expose bit-order or truncation faults in either direction. The falling-edge variant brings into reach the check that a rising direction clock never loads data. The rising-edge variant from the generate choice is not built by this bench.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } ubt_edge_e;

   localparam int UBT_DEF_WIDTH = 18;
endpackage

// File: rtl/ubt_edge_det.sv
module ubt_edge_det #(
   parameter ubt_pkg::ubt_edge_e EDGE = ubt_pkg::EDGE_FALL
) (
   input  logic clk,
   input  logic lvl,
   output logic hit
);
   logic lvl_q;

   // Sample keeps following the level during reset so no false edge appears.
   always_ff @(posedge clk) lvl_q <= lvl;

   generate
      if (EDGE == ubt_pkg::EDGE_FALL) begin : g_fall
         assign hit = lvl_q & ~lvl;
      end else begin : g_rise
         assign hit = ~lvl_q & lvl;
      end
   endgenerate
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane #(
   parameter int                 WIDTH = ubt_pkg::UBT_DEF_WIDTH,
   parameter ubt_pkg::ubt_edge_e EDGE  = ubt_pkg::EDGE_FALL
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   input  logic             pass,
   input  logic             dclk,
   input  logic             ce_n,
   input  logic             oe_n,
   output logic [WIDTH-1:0] dout,
   output logic             drv
);
   logic             edge_hit;
   logic             load;
   logic [WIDTH-1:0] held;

   ubt_edge_det #(.EDGE(EDGE)) edge_i (
      .clk (clk),
      .lvl (dclk),
      .hit (edge_hit)
   );

   // Tracking while passing keeps the last pass-through word once pass drops.
   assign load = pass | (edge_hit & ~ce_n);

   always_ff @(posedge clk) begin
      if (rst)       held <= '0;
      else if (load) held <= din;
   end

   assign dout = pass ? din : held;
   assign drv  = ~oe_n;
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
   parameter int                 WIDTH = ubt_pkg::UBT_DEF_WIDTH,
   parameter ubt_pkg::ubt_edge_e EDGE  = ubt_pkg::EDGE_FALL
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_drv,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_drv,
   input  logic             oe_ab_n,
   input  logic             le_ab,
   input  logic             clk_ab,
   input  logic             ce_ab_n,
   input  logic             oe_ba_n,
   input  logic             le_ba,
   input  logic             clk_ba,
   input  logic             ce_ba_n
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ubt_xcvr: WIDTH must be at least 1");
      end
   endgenerate

   ubt_lane #(.WIDTH(WIDTH), .EDGE(EDGE)) lane_ab_i (
      .clk  (clk),
      .rst  (rst),
      .din  (a_in),
      .pass (le_ab),
      .dclk (clk_ab),
      .ce_n (ce_ab_n),
      .oe_n (oe_ab_n),
      .dout (b_out),
      .drv  (b_drv)
   );

   ubt_lane #(.WIDTH(WIDTH), .EDGE(EDGE)) lane_ba_i (
      .clk  (clk),
      .rst  (rst),
      .din  (b_in),
      .pass (le_ba),
      .dclk (clk_ba),
      .ce_n (ce_ba_n),
      .oe_n (oe_ba_n),
      .dout (a_out),
      .drv  (a_drv)
   );
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
   parameter int                 WIDTH = ubt_pkg::UBT_DEF_WIDTH,
   parameter ubt_pkg::ubt_edge_e EDGE  = ubt_pkg::EDGE_FALL
) (
   input logic             clk,
   input logic             rst,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] a_out,
   input logic             a_drv,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic             b_drv,
   input logic             oe_ab_n,
   input logic             le_ab,
   input logic             clk_ab,
   input logic             ce_ab_n,
   input logic             oe_ba_n,
   input logic             le_ba,
   input logic             clk_ba,
   input logic             ce_ba_n
);
   logic ab_d, ba_d, ev_ab, ev_ba;

   always_ff @(posedge clk) begin
      ab_d <= clk_ab;
      ba_d <= clk_ba;
   end

   assign ev_ab = (EDGE == ubt_pkg::EDGE_FALL) ? (ab_d & ~clk_ab) : (~ab_d & clk_ab);
   assign ev_ba = (EDGE == ubt_pkg::EDGE_FALL) ? (ba_d & ~clk_ba) : (~ba_d & clk_ba);

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (le_ab || b_out == '0));

   a_r2_pass_ab: assert property (@(posedge clk) disable iff (rst)
      le_ab |-> (b_out == a_in));

   a_r3_hold_ab: assert property (@(posedge clk) disable iff (rst)
      (!le_ab && !ev_ab) |=> (le_ab || $stable(b_out)));

   a_r4_capture_ab: assert property (@(posedge clk) disable iff (rst)
      (!le_ab && ev_ab && !ce_ab_n) |=> (le_ab || b_out == $past(a_in)));

   a_r5_ce_blocks_ab: assert property (@(posedge clk) disable iff (rst)
      (!le_ab && ev_ab && ce_ab_n) |=> (le_ab || $stable(b_out)));

   a_r8_disabled_ports: assert property (@(posedge clk) disable iff (rst)
      (oe_ab_n |-> !b_drv) and (oe_ba_n |-> !a_drv));

   a_r9_pass_ba: assert property (@(posedge clk) disable iff (rst)
      le_ba |-> (a_out == b_in));

   a_r9_capture_ba: assert property (@(posedge clk) disable iff (rst)
      (!le_ba && ev_ba && !ce_ba_n) |=> (le_ba || a_out == $past(b_in)));

   a_r9_hold_ba: assert property (@(posedge clk) disable iff (rst)
      (!le_ba && !(ev_ba && !ce_ba_n)) |=> (le_ba || $stable(a_out)));
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.WIDTH(WIDTH), .EDGE(EDGE)) chk_i (
   .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
   .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
   .oe_ab_n(oe_ab_n), .le_ab(le_ab), .clk_ab(clk_ab), .ce_ab_n(ce_ab_n),
   .oe_ba_n(oe_ba_n), .le_ba(le_ba), .clk_ba(clk_ba), .ce_ba_n(ce_ba_n)
);

// File: tb/ubt_xcvr_tb_top.sv
`timescale 1ns/1ps
module ubt_xcvr_tb_top;
   localparam int W = 18;

   logic clk = 1'b0;
   logic rst;
   logic [W-1:0] a_in, b_in, a_out, b_out;
   logic a_drv, b_drv;
   logic oe_ab_n, le_ab, clk_ab, ce_ab_n;
   logic oe_ba_n, le_ba, clk_ba, ce_ba_n;
   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;

   always #5 clk = ~clk;

   ubt_xcvr dut_i (
      .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
      .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
      .oe_ab_n(oe_ab_n), .le_ab(le_ab), .clk_ab(clk_ab), .ce_ab_n(ce_ab_n),
      .oe_ba_n(oe_ba_n), .le_ba(le_ba), .clk_ba(clk_ba), .ce_ba_n(ce_ba_n)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One system clock: past the rising edge, back to the falling edge.
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst = 1'b1; a_in = '1; b_in = '1;
      oe_ab_n = 1'b0; le_ab = 1'b0; clk_ab = 1'b1; ce_ab_n = 1'b1;
      oe_ba_n = 1'b0; le_ba = 1'b0; clk_ba = 1'b1; ce_ba_n = 1'b1;
      repeat (3) step();
      rst = 1'b0;
      step();
      chk("R1 b_out after reset", b_out, '0);
      chk("R1 a_out after reset", a_out, '0);
      chk("R8 drive flags enabled", {16'd0, a_drv, b_drv}, 18'd3);
   endtask

   task automatic t_pass();
      le_ab = 1'b1; a_in = 18'h2AAAA; #1;
      chk("R2 pass pattern 1", b_out, 18'h2AAAA);
      a_in = 18'h15555; #1;
      chk("R2 pass pattern 2 same cycle", b_out, 18'h15555);
      step();
   endtask

   task automatic t_latch_hold();
      a_in = 18'h20001; step();
      le_ab = 1'b0; a_in = 18'h1FFFE; #1;
      chk("R7 value kept as pass drops", b_out, 18'h20001);
      step();
      chk("R7 value kept next cycle", b_out, 18'h20001);
      a_in = 18'h0F0F0; step();
      chk("R3 hold with steady clock high", b_out, 18'h20001);
   endtask

   task automatic t_clocked();
      ce_ab_n = 1'b0; clk_ab = 1'b0; a_in = 18'h3C3C3; step();
      chk("R4 falling edge loads", b_out, 18'h3C3C3);
      a_in = 18'h12345; step();
      chk("R3 hold with steady clock low", b_out, 18'h3C3C3);
      clk_ab = 1'b1; a_in = 18'h0ABCD; step();
      chk("R6 rising edge ignored", b_out, 18'h3C3C3);
      ce_ab_n = 1'b1; clk_ab = 1'b0; a_in = 18'h01111; step();
      chk("R5 edge blocked by enable", b_out, 18'h3C3C3);
      clk_ab = 1'b1; step();
      ce_ab_n = 1'b0; clk_ab = 1'b0; a_in = 18'h3FFFF; step();
      chk("R4 second load all ones", b_out, 18'h3FFFF);
   endtask

   task automatic t_oe();
      oe_ab_n = 1'b1; #1;
      chk("R8 b_drv low when disabled", {17'd0, b_drv}, 18'd0);
      a_in = 18'h00000; step();
      chk("R8 b_out kept while disabled", b_out, 18'h3FFFF);
      oe_ab_n = 1'b0; #1;
      chk("R8 b_drv back high", {17'd0, b_drv}, 18'd1);
      oe_ba_n = 1'b1; #1;
      chk("R8 a_drv low when disabled", {17'd0, a_drv}, 18'd0);
      oe_ba_n = 1'b0;
      step();
   endtask

   task automatic t_ba();
      le_ba = 1'b1; b_in = 18'h2D2D2; #1;
      chk("R9 pass B to A", a_out, 18'h2D2D2);
      step();
      le_ba = 1'b0; b_in = 18'h00777; step();
      chk("R9 hold B to A", a_out, 18'h2D2D2);
      ce_ba_n = 1'b0; clk_ba = 1'b0; b_in = 18'h18181; step();
      chk("R9 falling edge loads B to A", a_out, 18'h18181);
      chk("R9 A-to-B value untouched", b_out, 18'h3FFFF);
      clk_ab = 1'b1; step();
      clk_ab = 1'b0; a_in = 18'h05A5A; step();
      chk("R9 B-to-A value untouched by A-to-B load", a_out, 18'h18181);
   endtask

   initial begin
      t_reset();
      t_pass();
      t_latch_hold();
      t_clocked();
      t_oe();
      t_ba();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 5000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule